// File: doc/BRIEF.md
# Indexed and Indirect Address Sequencer

This block forms the address of each bus cycle for an 8-bit accumulator processor with a 13-bit memory bus. An opcode class and a store flag arrive in the opcode cycle. From then on the block walks the cycles of that addressing mode. Each cycle it drives the address and a write strobe, and it latches the operand bytes and pointer bytes that come back on the read data bus. It keeps the program counter and advances it on every opcode fetch and every operand fetch. An indirect jump loads the counter with the target it has fetched.

Two kinds of access handle a page crossing differently. An indexed load spends a fix-up cycle only when adding the index carries out of the low address byte. An indexed store always spends that cycle: it first reads at the uncorrected address, and the write comes one cycle later. The indirect jump never carries into the pointer's page when it fetches the target high byte. A done pulse marks the last cycle of each instruction, so a controller or a test can count the cycles spent in each mode.

Top module: `idxind_addr_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in the opcode-fetch cycle with the program counter at RESET_PC (default 0x0200) and clears the pointer registers and the extra-cycle flag. The first cycle after reset drives the counter value as the address, with the strobe low and done low.
- R2: Every final access address is 13 bits wide. Bits 12..8 are bits 4..0 of the high address byte, and bits 7..0 are the low byte.
- R3: The strobe `wr` is 1 in a write cycle and 0 in a read cycle. A store makes exactly one write, in its last cycle. A load or a jump makes none.
- R4: Opcode and operand fetch cycles drive the program counter on `addr`, and each one advances the counter by one. `mode_i` and `store_i` are sampled in the opcode cycle. The mode codes are: 0 absolute, 1 absolute+X, 2 absolute+Y, 3 zero-page indexed indirect (X), 4 indirect indexed (Y), 5 indirect jump, 6 and 7 single-cycle.
- R5: Absolute mode fetches the low byte, then the high byte, then accesses {high, low}. It takes 4 cycles.
- R6: Absolute indexed mode first reads at {base high, (base low + index) mod 256}, with the strobe low. A fix-up cycle keeps that same low byte.
- R7: An indexed load (modes 1, 2 and 4) adds a fix-up cycle only when base low + index exceeds 255. In that cycle the high byte is base high + 1. Otherwise the load ends on the uncorrected read: 4 cycles in modes 1 and 2, 5 cycles in mode 4.
- R8: An indexed store (modes 1, 2 and 4) always reads once at the uncorrected address. It writes in the next cycle, at base high + 1 if the low add carried and at base high otherwise. This takes 5 cycles in modes 1 and 2 and 6 cycles in mode 4.
- R9: Mode 3 reads the target low byte at (pointer + X) mod 256 and the high byte at (pointer + X + 1) mod 256, with address bits 12..8 at zero. It then accesses the target. It takes 5 cycles.
- R10: Mode 4 reads the base low byte at the pointer and the base high byte at (pointer + 1) mod 256, both in page zero. It then accesses the base plus Y, with 5 cycles for a load without carry and 6 cycles otherwise.
- R11: Mode 5 fetches the pointer low byte, then the pointer high byte. It reads the target low byte at the pointer, then the target high byte at {pointer high, (pointer low + 1) mod 256}, which never carries into the high byte. It loads the counter with the target, takes 5 cycles, and the next fetch is at the target.
- R12: `done` is high in exactly the last cycle of each instruction. Modes 6 and 7 end in their opcode cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Addressing mode class, sampled in the opcode cycle |
| store_i | input | 1 | 1 when the instruction writes memory, sampled in the opcode cycle |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| rd_data | input | 8 | Byte read from memory in the current cycle |
| addr | output | 13 | Memory address of the current cycle |
| wr | output | 1 | 1 for a write cycle, 0 for a read cycle |
| done | output | 1 | High in the last cycle of an instruction |
| pc | output | 13 | Program counter |

## Verification
The embedded assertions check the following on every cycle:
- the fetch that follows `done` lands on the counter;
- the counter steps by one on each fetch;
- a write only ever happens in a final cycle;
- an indexed store's uncorrected read is always followed by a write;
- a fix-up cycle keeps the low byte, and a load's fix-up cycle raises the page by one;
- the zero-page pointer reads stay in page zero;
- the second byte of the indirect jump stays in the pointer's page.

Only the bench's scenarios can show the rest. That covers the cycle count of each mode with and without a carry, the exact effective addresses built from the operand bytes, the target loaded by the jump, wrap-around at 0xFF in the pointer reads, and the effect of a reset taken in the middle of an instruction.

// File: rtl/adrseq_pkg.sv
package adrseq_pkg;
   typedef enum logic [2:0] {
      M_ABS  = 3'd0,
      M_ABX  = 3'd1,
      M_ABY  = 3'd2,
      M_IZX  = 3'd3,
      M_IZY  = 3'd4,
      M_JIND = 3'd5,
      M_ONE6 = 3'd6,
      M_ONE7 = 3'd7
   } mode_e;

   typedef enum logic [2:0] {
      S_OP,    // opcode fetch
      S_B1,    // first operand byte
      S_B2,    // second operand byte
      S_R1,    // first pointer-data read
      S_R2,    // second pointer-data read
      S_IDX,   // indexed access, uncorrected page
      S_FIX,   // page fix-up access
      S_ACC    // plain final access
   } state_e;
endpackage

// File: rtl/idx_adder.sv
module idx_adder #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W:0] full;
   assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
   assign sum  = full[W-1:0];
   assign cout = full[W];
endmodule

// File: rtl/prog_counter.sv
module prog_counter #(
   parameter int          AW       = 13,
   parameter logic [12:0] RESET_PC = 13'h0200
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          inc,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   output logic [AW-1:0] pc
);
   logic [AW-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (rst)       pc_q <= AW'(RESET_PC);
      else if (load) pc_q <= load_val;
      else if (inc)  pc_q <= pc_q + 1'b1;
   end

   assign pc = pc_q;

   AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
      (inc && !load) |=> (pc_q == AW'($past(pc_q) + 1'b1))); // R4
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
   import adrseq_pkg::*;
#(
   parameter int AW        = 13,
   parameter int DW        = 8,
   parameter bit JIND_WRAP = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [2:0]    mode_i,
   input  logic          store_i,
   input  logic [DW-1:0] idx_x,
   input  logic [DW-1:0] idx_y,
   input  logic [DW-1:0] rd_data,
   input  logic [AW-1:0] pc_i,
   output logic [AW-1:0] addr_o,
   output logic          wr_o,
   output logic          done_o,
   output logic          pc_inc_o,
   output logic          pc_load_o,
   output logic [AW-1:0] pc_val_o
);
   localparam int HB = AW - DW;

   state_e         state_q;
   mode_e          mode_q;
   logic           store_q;
   logic [DW-1:0]  lo_q;
   logic [HB-1:0]  hi_q;
   logic [DW-1:0]  ptr_q;
   logic [HB-1:0]  ptrh_q;
   logic           carry_q;

   logic [DW-1:0]  idx_sel, isum, ptr_off, psum;
   logic           icarry, ptr_cin, pco;
   logic [HB-1:0]  jhi, ptr_page;
   logic           one_cycle;

   assign idx_sel   = (mode_q == M_ABY || mode_q == M_IZY) ? idx_y : idx_x;
   assign ptr_off   = (mode_q == M_IZX) ? idx_x : '0;
   assign ptr_cin   = (state_q == S_R2);
   assign one_cycle = (mode_i == 3'd6) || (mode_i == 3'd7);

   idx_adder #(.W(DW)) u_index (
      .a(lo_q), .b(idx_sel), .cin(1'b0), .sum(isum), .cout(icarry));

   idx_adder #(.W(DW)) u_pointer (
      .a(ptr_q), .b(ptr_off), .cin(ptr_cin), .sum(psum), .cout(pco));

   // Jump target high-byte page: stay in the pointer page or carry into it.
   assign jhi      = JIND_WRAP ? ptrh_q : ptrh_q + {{(HB-1){1'b0}}, pco};
   assign ptr_page = (mode_q == M_JIND) ? ((state_q == S_R2) ? jhi : ptrh_q) : '0;

   always_comb begin
      addr_o    = pc_i;
      wr_o      = 1'b0;
      done_o    = 1'b0;
      pc_inc_o  = 1'b0;
      pc_load_o = 1'b0;
      pc_val_o  = {rd_data[HB-1:0], lo_q};
      unique case (state_q)
         S_OP: begin
            pc_inc_o = 1'b1;
            done_o   = one_cycle;
         end
         S_B1, S_B2: pc_inc_o = 1'b1;
         S_R1: addr_o = {ptr_page, psum};
         S_R2: begin
            addr_o = {ptr_page, psum};
            if (mode_q == M_JIND) begin
               done_o    = 1'b1;
               pc_load_o = 1'b1;
            end
         end
         S_IDX: begin
            addr_o = {hi_q, isum};
            done_o = !store_q && !icarry;
         end
         S_FIX: begin
            addr_o = {hi_q + {{(HB-1){1'b0}}, carry_q}, lo_q};
            wr_o   = store_q;
            done_o = 1'b1;
         end
         S_ACC: begin
            addr_o = {hi_q, lo_q};
            wr_o   = store_q;
            done_o = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= S_OP;
         mode_q  <= M_ABS;
         store_q <= 1'b0;
         lo_q    <= '0;
         hi_q    <= '0;
         ptr_q   <= '0;
         ptrh_q  <= '0;
         carry_q <= 1'b0;
      end else begin
         unique case (state_q)
            S_OP: begin
               mode_q  <= mode_e'(mode_i);
               store_q <= store_i;
               carry_q <= 1'b0;
               state_q <= one_cycle ? S_OP : S_B1;
            end
            S_B1: begin
               if (mode_q == M_IZX || mode_q == M_IZY || mode_q == M_JIND)
                  ptr_q <= rd_data;
               else
                  lo_q <= rd_data;
               state_q <= (mode_q == M_IZX || mode_q == M_IZY) ? S_R1 : S_B2;
            end
            S_B2: begin
               if (mode_q == M_JIND) begin
                  ptrh_q  <= rd_data[HB-1:0];
                  state_q <= S_R1;
               end else begin
                  hi_q    <= rd_data[HB-1:0];
                  state_q <= (mode_q == M_ABS) ? S_ACC : S_IDX;
               end
            end
            S_R1: begin
               lo_q    <= rd_data;
               state_q <= S_R2;
            end
            S_R2: begin
               hi_q <= rd_data[HB-1:0];
               if (mode_q == M_IZY)      state_q <= S_IDX;
               else if (mode_q == M_IZX) state_q <= S_ACC;
               else                      state_q <= S_OP;
            end
            S_IDX: begin
               lo_q    <= isum;
               carry_q <= icarry;
               state_q <= (!store_q && !icarry) ? S_OP : S_FIX;
            end
            default: state_q <= S_OP;
         endcase
      end
   end

   AST_WR_LAST_ONLY: assert property (@(posedge clk) disable iff (rst)
      wr_o |-> done_o); // R3
   AST_STORE_ALWAYS_FIX: assert property (@(posedge clk) disable iff (rst)
      (state_q == S_IDX && store_q) |=> wr_o); // R8
   AST_LOAD_FIX_PAGE: assert property (@(posedge clk) disable iff (rst)
      (state_q == S_FIX && !store_q) |->
         (addr_o[AW-1:DW] == HB'($past(addr_o[AW-1:DW]) + 1'b1))); // R7
   AST_FIX_LOW_HELD: assert property (@(posedge clk) disable iff (rst)
      (state_q == S_FIX) |-> (addr_o[DW-1:0] == $past(addr_o[DW-1:0]))); // R6
   AST_ZP_POINTER: assert property (@(posedge clk) disable iff (rst)
      ((state_q == S_R1 || state_q == S_R2) && mode_q != M_JIND) |->
         (addr_o[AW-1:DW] == '0)); // R9

   generate
      if (JIND_WRAP) begin : g_jind_wrap
         AST_JIND_SAME_PAGE: assert property (@(posedge clk) disable iff (rst)
            (state_q == S_R2 && mode_q == M_JIND) |->
               (addr_o[AW-1:DW] == $past(addr_o[AW-1:DW]) &&
                addr_o[DW-1:0] == DW'($past(addr_o[DW-1:0]) + 1'b1))); // R11
      end else begin : g_jind_carry
         AST_JIND_NEXT_ADDR: assert property (@(posedge clk) disable iff (rst)
            (state_q == S_R2 && mode_q == M_JIND) |->
               (addr_o == AW'($past(addr_o) + 1'b1))); // R11
      end
   endgenerate
endmodule

// File: rtl/idxind_addr_seq.sv
module idxind_addr_seq #(
   parameter int          AW        = 13,
   parameter int          DW        = 8,
   parameter logic [12:0] RESET_PC  = 13'h0200,
   parameter bit          JIND_WRAP = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [2:0]    mode_i,
   input  logic          store_i,
   input  logic [DW-1:0] idx_x,
   input  logic [DW-1:0] idx_y,
   input  logic [DW-1:0] rd_data,
   output logic [AW-1:0] addr,
   output logic          wr,
   output logic          done,
   output logic [AW-1:0] pc
);
   generate
      if (AW <= DW || AW > 2 * DW) begin : g_bad_width
         $error("address width must lie between DW+1 and 2*DW");
      end
   endgenerate

   logic          pc_inc, pc_load;
   logic [AW-1:0] pc_val;

   prog_counter #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
      .clk(clk), .rst(rst), .inc(pc_inc), .load(pc_load),
      .load_val(pc_val), .pc(pc));

   seq_fsm #(.AW(AW), .DW(DW), .JIND_WRAP(JIND_WRAP)) u_fsm (
      .clk(clk), .rst(rst), .mode_i(mode_i), .store_i(store_i),
      .idx_x(idx_x), .idx_y(idx_y), .rd_data(rd_data), .pc_i(pc),
      .addr_o(addr), .wr_o(wr), .done_o(done),
      .pc_inc_o(pc_inc), .pc_load_o(pc_load), .pc_val_o(pc_val));

   AST_FETCH_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
      done |=> (addr == pc && !wr)); // R4
endmodule

// File: tb/idxind_addr_seq_test.sv
module idxind_addr_seq_test;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic [2:0]  mode;
      logic        st;
      logic [7:0]  x, y, b1, b2, b3, b4;
      logic [3:0]  cyc;
      logic [12:0] fa;
      logic [2:0]  pk;
      logic [12:0] pa;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t V [NV] = '{
      '{3'd0, 1'b0, 8'h00, 8'h00, 8'h34, 8'h12, 8'h00, 8'h00, 4'd4, 13'h1234, 3'd7, 13'h0000},
      '{3'd0, 1'b1, 8'h00, 8'h00, 8'hCD, 8'hAB, 8'h00, 8'h00, 4'd4, 13'h0BCD, 3'd7, 13'h0000},
      '{3'd1, 1'b0, 8'h10, 8'h00, 8'h20, 8'h05, 8'h00, 8'h00, 4'd4, 13'h0530, 3'd3, 13'h0530},
      '{3'd1, 1'b0, 8'hF0, 8'h00, 8'h20, 8'h05, 8'h00, 8'h00, 4'd5, 13'h0610, 3'd3, 13'h0510},
      '{3'd2, 1'b1, 8'h00, 8'h01, 8'h10, 8'h03, 8'h00, 8'h00, 4'd5, 13'h0311, 3'd3, 13'h0311},
      '{3'd2, 1'b1, 8'h00, 8'h80, 8'h90, 8'h1F, 8'h00, 8'h00, 4'd5, 13'h0010, 3'd3, 13'h1F10},
      '{3'd3, 1'b0, 8'h05, 8'h00, 8'h40, 8'h78, 8'h16, 8'h00, 4'd5, 13'h1678, 3'd2, 13'h0045},
      '{3'd3, 1'b1, 8'h10, 8'h00, 8'hFF, 8'h11, 8'h02, 8'h00, 4'd5, 13'h0211, 3'd3, 13'h0010},
      '{3'd3, 1'b0, 8'h0F, 8'h00, 8'hF0, 8'h22, 8'h03, 8'h00, 4'd5, 13'h0322, 3'd3, 13'h0000},
      '{3'd4, 1'b0, 8'h00, 8'h04, 8'h80, 8'h10, 8'h07, 8'h00, 4'd5, 13'h0714, 3'd2, 13'h0080},
      '{3'd4, 1'b0, 8'h00, 8'hF0, 8'h80, 8'h20, 8'h07, 8'h00, 4'd6, 13'h0810, 3'd4, 13'h0710},
      '{3'd4, 1'b1, 8'h00, 8'h02, 8'hFF, 8'h30, 8'h01, 8'h00, 4'd6, 13'h0132, 3'd3, 13'h0000},
      '{3'd5, 1'b0, 8'h00, 8'h00, 8'h00, 8'h03, 8'h56, 8'h04, 4'd5, 13'h0301, 3'd3, 13'h0300},
      '{3'd5, 1'b0, 8'h00, 8'h00, 8'hFF, 8'h02, 8'h9A, 8'h01, 4'd5, 13'h0200, 3'd3, 13'h02FF}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  mode_i = 3'd0;
   logic        store_i = 1'b0;
   logic [7:0]  idx_x = 8'h00, idx_y = 8'h00, rd_data = 8'h00;
   logic [12:0] addr, pc;
   logic        wr, done;

   int n_chk = 0;
   int n_fail = 0;
   logic [12:0] pc_exp;

   idxind_addr_seq uut (
      .clk(clk), .rst(rst), .mode_i(mode_i), .store_i(store_i),
      .idx_x(idx_x), .idx_y(idx_y), .rd_data(rd_data),
      .addr(addr), .wr(wr), .done(done), .pc(pc));

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic string mode_tag(input logic [2:0] m, input logic s);
      case (m)
         3'd0: return "R5";
         3'd1, 3'd2: return s ? "R8" : "R7";
         3'd3: return "R9";
         3'd4: return s ? "R8" : "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic run_vec(input vec_t v);
      logic [12:0] a_log [8];
      logic [7:0]  bytes [5];
      int          cyc = 0;
      int          nwr = 0;
      bytes = '{8'h00, v.b1, v.b2, v.b3, v.b4};
      for (int k = 0; k < 8; k++) begin
         mode_i  = v.mode;
         store_i = v.st;
         idx_x   = v.x;
         idx_y   = v.y;
         rd_data = (k < 5) ? bytes[k] : 8'h00;
         #1;
         a_log[k] = addr;
         if (wr) nwr++;
         if (k == 0) chk(addr == pc_exp && !wr, "R4 fetch address", addr, pc_exp);
         if (done) begin
            cyc = k + 1;
            chk(addr == v.fa, {mode_tag(v.mode, v.st), " R2 final address"}, addr, v.fa);
            chk(wr == v.st, "R3 final strobe", wr, v.st);
            break;
         end
         @(negedge clk);
      end
      chk(cyc == v.cyc, {mode_tag(v.mode, v.st), " R12 cycle count"}, cyc, v.cyc);
      chk(nwr == v.st, "R3 write count", nwr, v.st);
      if (v.pk != 3'd7 && v.pk < cyc)
         chk(a_log[v.pk] == v.pa, {mode_tag(v.mode, v.st), " R6 intermediate address"},
             a_log[v.pk], v.pa);
      if (v.mode == 3'd5)      pc_exp = {v.b4[4:0], v.b3};
      else if (v.mode >= 3'd3) pc_exp = pc_exp + 13'd2;
      else                     pc_exp = pc_exp + 13'd3;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 50000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      pc_exp = 13'h0200;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      chk(addr == 13'h0200, "R1 reset address", addr, 13'h0200);
      chk(!wr && !done, "R1 reset strobe and done", {wr, done}, 0);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) run_vec(V[i]);

      // R12: single-cycle class finishes in its opcode cycle
      mode_i = 3'd6;
      #1;
      chk(done && addr == pc_exp, "R12 single-cycle done", {done, addr}, {1'b1, pc_exp});
      @(negedge clk);
      pc_exp = pc_exp + 13'd1;
      mode_i = 3'd7;
      #1;
      chk(done && addr == pc_exp, "R4 R12 next fetch after single-cycle", addr, pc_exp);
      @(negedge clk);
      pc_exp = pc_exp + 13'd1;

      // R1: reset in the middle of an instruction
      mode_i  = 3'd4;
      store_i = 1'b1;
      rd_data = 8'h33;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      mode_i = 3'd0;
      store_i = 1'b0;
      #1;
      chk(addr == 13'h0200 && !done && !wr, "R1 mid-instruction reset", addr, 13'h0200);
      pc_exp = 13'h0200;
      @(negedge clk);
      pc_exp = 13'h0201;
      #1;
      chk(addr == pc_exp, "R4 operand fetch after reset", addr, pc_exp);
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      pc_exp = 13'h0203;
      #1;
      chk(addr == pc_exp, "R4 fetch after reset instruction", addr, pc_exp);

      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule